// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator value, the general register value and an 8-bit operation code. It produces the operation's result without any clock delay. It also computes new zero, carry, overflow and negative flags. These flags are loaded into a four-bit status register on the next rising clock edge, but only while the write strobe is high.

Each operation class writes its own subset of the flags, and the flags outside that subset keep their stored values:

- Arithmetic, rotate and shift operations write all four flags.
- Bitwise operations write only zero and negative.
- Clear loads a fixed pattern.

An operation code the block does not recognise passes the accumulator through unchanged and leaves every flag alone. The surrounding sequencer decides when to assert the strobe. No stream handshake is involved: the operands, the code and the strobe are plain control inputs, sampled at the clock edge.

Top module: `acc_alu`

## Requirements
- R1: Any code other than 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x12, 0x13, 0x14 and 0x15 gives a result equal to the accumulator input and leaves all four flags unchanged, even with the strobe high.
- R2: Code 0x08 (add) gives accumulator plus register, modulo 256. Carry is the carry out of bit 7. Overflow is set when both operands have the same sign and the result's sign differs from it.
- R3: Code 0x09 (subtract) gives accumulator minus register, modulo 256. Carry is 1 when the accumulator is greater than or equal to the register as an unsigned number, meaning no borrow. Overflow is set when the operand signs differ and the result's sign differs from the accumulator's sign.
- R4: Code 0x0A (increment) gives accumulator plus one. Carry is set only for 0xFF and overflow is set only for 0x7F.
- R5: Code 0x0B (clear) gives a result of 0 and loads the flags with zero=1, carry=0, overflow=0, negative=0.
- R6: Codes 0x0C, 0x0D, 0x0E and 0x0F give AND, OR and XOR of the two operands, and NOT of the accumulator, in that order. They write only zero and negative; carry and overflow keep their prior values.
- R7: Code 0x12 rotates left and code 0x13 rotates right by one bit. Carry takes the bit that leaves the word. Overflow is set when bit 7 of the result differs from bit 7 of the accumulator.
- R8: Code 0x14 shifts left and code 0x15 shifts right by one bit, filling the vacated bit with 0. Carry and overflow follow the same rules as in R7.
- R9: For every recognised code, zero is set exactly when the 8-bit result is 0 and negative is a copy of result bit 7. This holds unless R6 says a flag is kept.
- R10: The status output is registered with zero at bit 0, carry at bit 1, overflow at bit 2 and negative at bit 3. The result output is combinational from the inputs.
- R11: While the write strobe is low the status register holds its value, whatever the code and operands.
- R12: An active-low asynchronous reset clears the status register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; status register loads on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 8 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| reg_i | input | 8 | General register operand |
| wr_en_i | input | 1 | Status register write strobe |
| result_o | output | 8 | Combinational operation result |
| flags_o | output | 4 | Status register {negative, overflow, carry, zero} |

## Verification
The clocked assertions compare the status register after an edge with the code, strobe and result present before that edge. They assume these inputs are settled ahead of the rising edge and stay constant through it. To meet that, the bench changes every input only on the falling clock edge. It then samples the result half a cycle before the rising edge and samples the flags just after it. The carry checks inside the arithmetic unit assume the operands are known values, so the bench never leaves an operand undriven once reset is released.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_W = 4;
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FV = 2;
  localparam int FN = 3;

  typedef enum logic [7:0] {
    OP_ADD  = 8'h08,
    OP_SUB  = 8'h09,
    OP_INC  = 8'h0A,
    OP_CLR  = 8'h0B,
    OP_AND  = 8'h0C,
    OP_OR   = 8'h0D,
    OP_XOR  = 8'h0E,
    OP_NOT  = 8'h0F,
    OP_ROL  = 8'h12,
    OP_ROR  = 8'h13,
    OP_SHL  = 8'h14,
    OP_SHR  = 8'h15
  } alu_op_e;

  typedef enum logic [2:0] {
    U_NONE,
    U_ARITH,
    U_BITW,
    U_SHIFT,
    U_CLEAR
  } unit_e;

  localparam logic [1:0] AR_ADD = 2'd0;
  localparam logic [1:0] AR_SUB = 2'd1;
  localparam logic [1:0] AR_INC = 2'd2;

  localparam logic [1:0] BW_AND = 2'd0;
  localparam logic [1:0] BW_OR  = 2'd1;
  localparam logic [1:0] BW_XOR = 2'd2;
  localparam logic [1:0] BW_NOT = 2'd3;

  localparam logic [1:0] SH_ROL = 2'd0;
  localparam logic [1:0] SH_ROR = 2'd1;
  localparam logic [1:0] SH_SHL = 2'd2;
  localparam logic [1:0] SH_SHR = 2'd3;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0] op,
  output unit_e          unit,
  output logic [1:0]     sel
);

  always_comb begin
    unit = U_NONE;
    sel  = 2'd0;
    case (op)
      OP_ADD: begin unit = U_ARITH; sel = AR_ADD; end
      OP_SUB: begin unit = U_ARITH; sel = AR_SUB; end
      OP_INC: begin unit = U_ARITH; sel = AR_INC; end
      OP_CLR: begin unit = U_CLEAR; sel = 2'd0;   end
      OP_AND: begin unit = U_BITW;  sel = BW_AND; end
      OP_OR:  begin unit = U_BITW;  sel = BW_OR;  end
      OP_XOR: begin unit = U_BITW;  sel = BW_XOR; end
      OP_NOT: begin unit = U_BITW;  sel = BW_NOT; end
      OP_ROL: begin unit = U_SHIFT; sel = SH_ROL; end
      OP_ROR: begin unit = U_SHIFT; sel = SH_ROR; end
      OP_SHL: begin unit = U_SHIFT; sel = SH_SHL; end
      OP_SHR: begin unit = U_SHIFT; sel = SH_SHR; end
      default: begin unit = U_NONE; sel = 2'd0; end
    endcase
  end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] res,
  output logic          c,
  output logic          v
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] opnd;
  logic          cin;
  logic [DW:0]   sum;
  logic [DW:0]   chk_add;

  // subtract is a + ~b + 1, so the carry out is the no-borrow indication
  always_comb begin
    case (sel)
      AR_SUB:  begin opnd = ~b; cin = 1'b1; end
      AR_INC:  begin opnd = {{(DW-1){1'b0}}, 1'b1}; cin = 1'b0; end
      default: begin opnd = b;  cin = 1'b0; end
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, opnd} + {{DW{1'b0}}, cin};
  assign res = sum[DW-1:0];
  assign c   = sum[DW];
  assign v   = (a[MSB] == opnd[MSB]) && (res[MSB] != a[MSB]);

  assign chk_add = {1'b0, a} + {1'b0, b};

  // carry rules checked against plain unsigned arithmetic
  always_comb begin
    if (sel == AR_SUB) begin
      p_sub_carry_r3: assert (c == (a >= b));
    end
    if (sel == AR_ADD) begin
      p_add_carry_r2: assert (c == chk_add[DW]);
    end
  end

endmodule

// File: rtl/acc_alu_bitw.sv
module acc_alu_bitw
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] res
);

  always_comb begin
    case (sel)
      BW_AND:  res = a & b;
      BW_OR:   res = a | b;
      BW_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [1:0]    sel,
  output logic [DW-1:0] res,
  output logic          c,
  output logic          v
);

  localparam int MSB = DW - 1;

  always_comb begin
    case (sel)
      SH_ROL:  begin res = {a[MSB-1:0], a[MSB]}; c = a[MSB]; end
      SH_ROR:  begin res = {a[0], a[MSB:1]};     c = a[0];   end
      SH_SHL:  begin res = {a[MSB-1:0], 1'b0};   c = a[MSB]; end
      default: begin res = {1'b0, a[MSB:1]};     c = a[0];   end
    endcase
  end

  assign v = a[MSB] ^ res[MSB];

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] newf,
  output logic [FLAG_W-1:0] flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (we) begin
      flags_q <= (flags_q & ~mask) | (newf & mask);
    end
  end

  // strobe low: register holds
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> flags_q == $past(flags_q));

  // bits outside the operation's subset are never disturbed
  p_keep_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((flags_q ^ $past(flags_q)) & ~$past(mask)) == '0);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OPW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPW-1:0]    op_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     reg_i,
  input  logic              wr_en_i,
  output logic [DW-1:0]     result_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int MSB = DW - 1;
  localparam logic [FLAG_W-1:0] M_ALL  = '1;
  localparam logic [FLAG_W-1:0] M_ZN   = FLAG_W'((1 << FZ) | (1 << FN));
  localparam logic [FLAG_W-1:0] CLR_PAT = FLAG_W'(1 << FZ);

  unit_e         unit;
  logic [1:0]    sel;
  logic [DW-1:0] ar_res, bw_res, sh_res;
  logic          ar_c, ar_v, sh_c, sh_v;
  logic [FLAG_W-1:0] newf, mask;
  logic          z_flag, n_flag;

  acc_alu_decode #(.OPW(OPW)) u_dec (
    .op  (op_i),
    .unit(unit),
    .sel (sel)
  );

  acc_alu_arith #(.DW(DW)) u_arith (
    .a  (acc_i),
    .b  (reg_i),
    .sel(sel),
    .res(ar_res),
    .c  (ar_c),
    .v  (ar_v)
  );

  acc_alu_bitw #(.DW(DW)) u_bitw (
    .a  (acc_i),
    .b  (reg_i),
    .sel(sel),
    .res(bw_res)
  );

  acc_alu_shift #(.DW(DW)) u_shift (
    .a  (acc_i),
    .sel(sel),
    .res(sh_res),
    .c  (sh_c),
    .v  (sh_v)
  );

  always_comb begin
    case (unit)
      U_ARITH: result_o = ar_res;
      U_BITW:  result_o = bw_res;
      U_SHIFT: result_o = sh_res;
      U_CLEAR: result_o = '0;
      default: result_o = acc_i;
    endcase
  end

  assign z_flag = (result_o == '0);
  assign n_flag = result_o[MSB];

  always_comb begin
    newf = '0;
    mask = '0;
    case (unit)
      U_ARITH: begin
        newf[FZ] = z_flag; newf[FC] = ar_c; newf[FV] = ar_v; newf[FN] = n_flag;
        mask = M_ALL;
      end
      U_SHIFT: begin
        newf[FZ] = z_flag; newf[FC] = sh_c; newf[FV] = sh_v; newf[FN] = n_flag;
        mask = M_ALL;
      end
      U_BITW: begin
        newf[FZ] = z_flag; newf[FN] = n_flag;
        mask = M_ZN;
      end
      U_CLEAR: begin
        newf = CLR_PAT;
        mask = M_ALL;
      end
      default: begin
        newf = '0;
        mask = '0;
      end
    endcase
  end

  acc_alu_flagreg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en_i),
    .mask   (mask),
    .newf   (newf),
    .flags_q(flags_o)
  );

  // clear loads its fixed pattern
  p_clear_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_CLR) |=> flags_o == CLR_PAT);

  // zero and negative track the result of any recognised code
  p_zero_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && unit != U_NONE) |=> flags_o[FZ] == ($past(result_o) == '0));

  p_neg_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && unit != U_NONE) |=> flags_o[FN] == $past(result_o[MSB]));

  // unrecognised code leaves the status alone
  p_unknown_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (unit == U_NONE) |=> flags_o == $past(flags_o));

endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_i = 8'h00;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] reg_i = 8'h00;
  logic       wr_en_i = 1'b0;
  logic [7:0] result_o;
  logic [3:0] flags_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_alu dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .reg_i   (reg_i),
    .wr_en_i (wr_en_i),
    .result_o(result_o),
    .flags_o (flags_o)
  );

  // {op, acc, reg, expected result, expected flags {N,V,C,Z}}; flags chain from row to row
  localparam logic [35:0] VECS [0:20] = '{
    {8'h08, 8'h7F, 8'h01, 8'h80, 4'hC},
    {8'h0C, 8'h0F, 8'hF0, 8'h00, 4'h5},
    {8'h08, 8'hFF, 8'h01, 8'h00, 4'h3},
    {8'h0D, 8'h80, 8'h01, 8'h81, 4'hA},
    {8'h09, 8'h05, 8'h03, 8'h02, 4'h2},
    {8'h09, 8'h03, 8'h05, 8'hFE, 4'h8},
    {8'h09, 8'h80, 8'h01, 8'h7F, 4'h6},
    {8'h0E, 8'hAA, 8'hAA, 8'h00, 4'h7},
    {8'h0A, 8'h7F, 8'h00, 8'h80, 4'hC},
    {8'h0A, 8'hFF, 8'h00, 8'h00, 4'h3},
    {8'h0F, 8'h0F, 8'h00, 8'hF0, 4'hA},
    {8'h0B, 8'h55, 8'h00, 8'h00, 4'h1},
    {8'h12, 8'h81, 8'h00, 8'h03, 4'h6},
    {8'h13, 8'h01, 8'h00, 8'h80, 4'hE},
    {8'h14, 8'h40, 8'h00, 8'h80, 4'hC},
    {8'h15, 8'h80, 8'h00, 8'h40, 4'h4},
    {8'h15, 8'h01, 8'h00, 8'h00, 4'h3},
    {8'h14, 8'h80, 8'h00, 8'h00, 4'h7},
    {8'h10, 8'h3C, 8'h00, 8'h3C, 4'h7},
    {8'h08, 8'h50, 8'h50, 8'hA0, 4'hC},
    {8'h13, 8'h02, 8'h00, 8'h01, 4'h0}
  };

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h08: return "R2";
      8'h09: return "R3";
      8'h0A: return "R4";
      8'h0B: return "R5";
      8'h0C, 8'h0D, 8'h0E, 8'h0F: return "R6";
      8'h12, 8'h13: return "R7";
      8'h14, 8'h15: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, check result before rising edge, flags after it
  task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic we, input logic [7:0] exp_res,
                       input logic [3:0] exp_flg, input string req);
    @(negedge clk);
    op_i = op; acc_i = a; reg_i = b; wr_en_i = we;
    #1;
    check(req, "result", result_o, exp_res);
    @(posedge clk);
    #1;
    check(req, "flags (R9/R10)", {4'h0, flags_o}, {4'h0, exp_flg});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12", "flags in reset", {4'h0, flags_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 21; i++) begin
      apply(VECS[i][35:28], VECS[i][27:20], VECS[i][19:12], 1'b1,
            VECS[i][11:4], VECS[i][3:0], req_of(VECS[i][35:28]));
    end

    // R11: strobe low, add that would set Z and C; result still shown, flags hold at 0
    apply(8'h08, 8'hFF, 8'h01, 1'b0, 8'h00, 4'h0, "R11");
    // same operation with strobe high
    apply(8'h08, 8'hFF, 8'h01, 1'b1, 8'h00, 4'h3, "R2");
    // R11: clear with strobe low leaves flags at 3
    apply(8'h0B, 8'hAB, 8'h00, 1'b0, 8'h00, 4'h3, "R11");
    // R1: unknown code with strobe high, flags kept
    apply(8'hFF, 8'h9E, 8'h11, 1'b1, 8'h9E, 4'h3, "R1");

    // R12: asynchronous reset mid-run clears the flags without a clock edge
    @(negedge clk);
    wr_en_i = 1'b0;
    #1;
    rst_n = 1'b0;
    #1;
    check("R12", "flags after async reset", {4'h0, flags_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    apply(8'h0B, 8'h12, 8'h00, 1'b1, 8'h00, 4'h1, "R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule